// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block lets a clocked host read and write a word-organised asynchronous static RAM that has per-byte strobes. The host raises a request together with an address, a read/write flag, byte enables and, for writes, a data word. It holds these until a one-cycle acknowledge returns. For a read, the acknowledge carries the sampled word.

On the memory side the controller drives an active-low chip enable, output enable, write enable and one active-low strobe per byte lane. It also drives the address and the outgoing data, plus a data-drive enable. The bidirectional bus itself is built outside the block from that data, that enable and the returned input word. All memory-side controls are driven from registers. Each timing interval is a parameter counted in clock cycles: address/data setup before the write pulse, write pulse width, data hold after it, read access window, and bus turnaround after a read.

Top module: `sram_ctl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, chip enable, write enable, output enable and every byte strobe are high, the data-drive enable is low and the acknowledge is low.
- R2: A write holds chip enable low with address and data driven for T_ASU cycles, then holds write enable low for exactly T_WPULSE cycles, then keeps data driven with write enable high for T_WHOLD cycles. Address, data and strobes do not change while write enable is low.
- R3: Strobe bit i controls data bits 8*i+7 down to 8*i: bit 0 is the lower byte (7:0) and bit 1 is the upper byte (15:8). During an access, strobe i is low exactly when host byte enable i is 1. A lane whose enable is 0 keeps its old memory contents on a write.
- R4: A read holds output enable low for exactly T_RACC cycles, with write enable high and data drive off. The input word is sampled at the clock edge that ends this window. A lane whose enable is 0 returns zero in the read word.
- R5: The acknowledge is a single-cycle pulse. Counting from the first cycle in which chip enable is low, it arrives T_ASU+T_WPULSE+T_WHOLD cycles later for a write and T_RACC cycles later for a read. A read acknowledge carries the read word.
- R6: Outside an access, chip enable, output enable, write enable and all strobes are high and data drive is off.
- R7: A write with both byte enables 0 pulls no strobe low and leaves the memory unchanged.
- R8: Host inputs are sampled only when a request is accepted. A request seen in the acknowledge cycle is not accepted. Changing the address, data or enables during an access has no effect on it.
- R9: Output enable is never low while data drive is on. Data drive starts no sooner than T_TURN+1 cycles after output enable rises.
- R10: The memory address equals the accepted host address (18 bits) for the whole access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Request, held until acknowledge |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | AW | Word address |
| host_wdata | input | DW | Write word |
| host_be | input | DW/8 | Byte enables, bit i = bits 8i+7:8i |
| host_ack | output | 1 | One-cycle completion pulse |
| host_rdata | output | DW | Read word, valid with acknowledge |
| sram_ce_n | output | 1 | Chip enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_bs_n | output | DW/8 | Byte strobes, active low |
| sram_addr | output | AW | Memory address |
| sram_dq_out | output | DW | Data to the memory |
| sram_dq_oe | output | 1 | Data drive enable |
| sram_dq_in | input | DW | Data from the memory bus |

## Verification
Several properties are checked on every cycle:
- the exact write-pulse and read-window lengths;
- the rule that output enable and data drive never overlap;
- the turnaround gap before driving;
- the data still being driven when write enable rises;
- stable address, data and strobes under the write pulse;
- the idle pin state;
- the single-cycle acknowledge.

Only the bench scenarios can show the rest: that byte masking actually merges lanes in memory, that disabled lanes read as zero, that host inputs scrambled mid-access leave the result untouched, and the exact request-to-acknowledge latency. The bench shows these by comparing a bus-level memory model against a reference memory.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WSET,
      ST_WPULSE,
      ST_WHOLD,
      ST_RACC,
      ST_TURN
   } sram_st_e;

   function automatic int max_of(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
module sram_ctl_timer #(
   parameter int CW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          done
);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign done = (cnt_q == '0);

endmodule

// File: rtl/sram_ctl_lanes.sv
module sram_ctl_lanes #(
   parameter int LANES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               accept,
   input  logic               active_nxt,
   input  logic               capture,
   input  logic [LANES-1:0]   host_be,
   input  logic [LANES*8-1:0] dq_in,
   output logic [LANES-1:0]   bs_n,
   output logic [LANES*8-1:0] rdata
);

   logic [LANES-1:0] be_q;
   logic [LANES-1:0] be_sel;

   assign be_sel = accept ? host_be : be_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         be_q <= '0;
      else if (accept)
         be_q <= host_be;
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            bs_n[i]        <= 1'b1;
            rdata[i*8 +: 8] <= '0;
         end else begin
            bs_n[i] <= active_nxt ? ~be_sel[i] : 1'b1;
            if (capture)
               rdata[i*8 +: 8] <= be_q[i] ? dq_in[i*8 +: 8] : 8'h00;
         end
      end
   end

endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
   import sram_ctl_pkg::*;
#(
   parameter int AW       = 18,
   parameter int DW       = 16,
   parameter int T_ASU    = 1,
   parameter int T_WPULSE = 3,
   parameter int T_WHOLD  = 1,
   parameter int T_RACC   = 4,
   parameter int T_TURN   = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            host_req,
   input  logic            host_wr,
   input  logic [AW-1:0]   host_addr,
   input  logic [DW-1:0]   host_wdata,
   input  logic [DW/8-1:0] host_be,
   output logic            host_ack,
   output logic [DW-1:0]   host_rdata,
   output logic            sram_ce_n,
   output logic            sram_oe_n,
   output logic            sram_we_n,
   output logic [DW/8-1:0] sram_bs_n,
   output logic [AW-1:0]   sram_addr,
   output logic [DW-1:0]   sram_dq_out,
   output logic            sram_dq_oe,
   input  logic [DW-1:0]   sram_dq_in
);

   localparam int LANES = DW / 8;
   localparam int MAXT  = max_of(max_of(max_of(T_ASU, T_WPULSE), max_of(T_WHOLD, T_RACC)), T_TURN);
   localparam int CW    = $clog2(MAXT + 1);

   if (DW % 8 != 0 || DW < 8) begin : g_bad_dw
      $error("sram_ctl: DW must be a positive multiple of 8");
   end
   if (AW < 1) begin : g_bad_aw
      $error("sram_ctl: AW must be at least 1");
   end
   if (T_ASU < 1 || T_WPULSE < 1 || T_WHOLD < 1 || T_RACC < 1 || T_TURN < 1) begin : g_bad_t
      $error("sram_ctl: every interval must be at least one cycle");
   end

   sram_st_e      st_q, st_d;
   logic          ld, tdone, accept, capture, ack_d;
   logic [CW-1:0] ld_val;
   logic          nx_wr, nx_act;
   logic [AW-1:0] addr_q;
   logic [DW-1:0] wdata_q;

   sram_ctl_timer #(.CW(CW)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ld),
      .load_val (ld_val),
      .done     (tdone)
   );

   always_comb begin
      st_d    = st_q;
      ld      = 1'b0;
      ld_val  = '0;
      accept  = 1'b0;
      capture = 1'b0;
      ack_d   = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            if (host_req && !host_ack) begin
               accept = 1'b1;
               ld     = 1'b1;
               if (host_wr) begin
                  st_d   = ST_WSET;
                  ld_val = CW'(T_ASU - 1);
               end else begin
                  st_d   = ST_RACC;
                  ld_val = CW'(T_RACC - 1);
               end
            end
         end
         ST_WSET: begin
            if (tdone) begin
               st_d   = ST_WPULSE;
               ld     = 1'b1;
               ld_val = CW'(T_WPULSE - 1);
            end
         end
         ST_WPULSE: begin
            if (tdone) begin
               st_d   = ST_WHOLD;
               ld     = 1'b1;
               ld_val = CW'(T_WHOLD - 1);
            end
         end
         ST_WHOLD: begin
            if (tdone) begin
               st_d  = ST_IDLE;
               ack_d = 1'b1;
            end
         end
         ST_RACC: begin
            if (tdone) begin
               st_d    = ST_TURN;
               ld      = 1'b1;
               ld_val  = CW'(T_TURN - 1);
               capture = 1'b1;
               ack_d   = 1'b1;
            end
         end
         ST_TURN: begin
            if (tdone)
               st_d = ST_IDLE;
         end
         default: st_d = ST_IDLE;
      endcase
   end

   assign nx_wr  = (st_d == ST_WSET) || (st_d == ST_WPULSE) || (st_d == ST_WHOLD);
   assign nx_act = nx_wr || (st_d == ST_RACC);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         sram_ce_n  <= 1'b1;
         sram_we_n  <= 1'b1;
         sram_oe_n  <= 1'b1;
         sram_dq_oe <= 1'b0;
         host_ack   <= 1'b0;
         addr_q     <= '0;
         wdata_q    <= '0;
      end else begin
         st_q       <= st_d;
         sram_ce_n  <= !nx_act;
         sram_we_n  <= (st_d != ST_WPULSE);
         sram_oe_n  <= (st_d != ST_RACC);
         sram_dq_oe <= nx_wr;
         host_ack   <= ack_d;
         if (accept) begin
            addr_q <= host_addr;
            if (host_wr)
               wdata_q <= host_wdata;
         end
      end
   end

   assign sram_addr   = addr_q;
   assign sram_dq_out = wdata_q;

   sram_ctl_lanes #(.LANES(LANES)) u_lanes (
      .clk        (clk),
      .rst_n      (rst_n),
      .accept     (accept),
      .active_nxt (nx_act),
      .capture    (capture),
      .host_be    (host_be),
      .dq_in      (sram_dq_in),
      .bs_n       (sram_bs_n),
      .rdata      (host_rdata)
   );

endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk #(
   parameter int AW       = 18,
   parameter int DW       = 16,
   parameter int T_WPULSE = 3,
   parameter int T_RACC   = 4,
   parameter int T_TURN   = 2
) (
   input logic            clk,
   input logic            rst_n,
   input logic            host_ack,
   input logic            sram_ce_n,
   input logic            sram_oe_n,
   input logic            sram_we_n,
   input logic [DW/8-1:0] sram_bs_n,
   input logic [AW-1:0]   sram_addr,
   input logic [DW-1:0]   sram_dq_out,
   input logic            sram_dq_oe
);

   logic [31:0] we_low_cnt, oe_low_cnt, gap_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         we_low_cnt <= '0;
         oe_low_cnt <= '0;
         gap_cnt    <= 32'(T_TURN + 1);
      end else begin
         we_low_cnt <= sram_we_n ? '0 : we_low_cnt + 1;
         oe_low_cnt <= sram_oe_n ? '0 : oe_low_cnt + 1;
         if (!sram_oe_n)
            gap_cnt <= '0;
         else if (gap_cnt < 32'(T_TURN + 1))
            gap_cnt <= gap_cnt + 1;
      end
   end

   a_r1_idle_after_reset: assert property (@(posedge clk)
      $rose(rst_n) |-> sram_ce_n && sram_we_n && sram_oe_n && !sram_dq_oe && !host_ack);

   a_r2_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sram_we_n) |-> we_low_cnt == 32'(T_WPULSE));

   a_r2_setup_before_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sram_we_n) |-> $past(!sram_ce_n) && $past(sram_dq_oe));

   a_r2_hold_at_pulse_end: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sram_we_n) |-> sram_dq_oe && !sram_ce_n && $stable(sram_dq_out) && $stable(sram_addr));

   a_r2_stable_under_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (!sram_we_n && $past(!sram_we_n)) |-> $stable(sram_addr) && $stable(sram_dq_out) && $stable(sram_bs_n));

   a_r4_read_window: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sram_oe_n) |-> oe_low_cnt == 32'(T_RACC) && host_ack);

   a_r4_read_controls: assert property (@(posedge clk) disable iff (!rst_n)
      !sram_oe_n |-> sram_we_n && !sram_ce_n);

   a_r5_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
      host_ack |=> !host_ack);

   a_r6_standby_pins: assert property (@(posedge clk) disable iff (!rst_n)
      sram_ce_n |-> (&sram_bs_n) && sram_oe_n && sram_we_n && !sram_dq_oe);

   a_r9_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      !(!sram_oe_n && sram_dq_oe));

   a_r9_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sram_dq_oe) |-> gap_cnt >= 32'(T_TURN + 1));

endmodule

bind sram_ctl sram_ctl_chk #(
   .AW(AW), .DW(DW), .T_WPULSE(T_WPULSE), .T_RACC(T_RACC), .T_TURN(T_TURN)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .host_ack    (host_ack),
   .sram_ce_n   (sram_ce_n),
   .sram_oe_n   (sram_oe_n),
   .sram_we_n   (sram_we_n),
   .sram_bs_n   (sram_bs_n),
   .sram_addr   (sram_addr),
   .sram_dq_out (sram_dq_out),
   .sram_dq_oe  (sram_dq_oe)
);

// File: tb/sram_ctl_test.sv
`timescale 1ns/1ps
module sram_ctl_test;

   localparam int AW = 18, DW = 16;
   localparam int T_ASU = 1, T_WPULSE = 3, T_WHOLD = 1, T_RACC = 4, T_TURN = 2;
   localparam int WR_LAT = T_ASU + T_WPULSE + T_WHOLD;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic host_req = 1'b0, host_wr = 1'b0;
   logic [AW-1:0] host_addr = '0;
   logic [DW-1:0] host_wdata = '0;
   logic [1:0] host_be = '0;
   logic host_ack;
   logic [DW-1:0] host_rdata;
   logic sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe;
   logic [1:0] sram_bs_n;
   logic [AW-1:0] sram_addr;
   logic [DW-1:0] sram_dq_out, sram_dq_in;

   int checks = 0, errors = 0, cyc = 0;
   logic [15:0] model_mem [int unsigned];
   logic [15:0] ref_mem [int unsigned];

   always #10 clk = ~clk;

   sram_ctl #(.AW(AW), .DW(DW), .T_ASU(T_ASU), .T_WPULSE(T_WPULSE), .T_WHOLD(T_WHOLD),
              .T_RACC(T_RACC), .T_TURN(T_TURN)) uut (
      .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_wr(host_wr),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_be(host_be),
      .host_ack(host_ack), .host_rdata(host_rdata), .sram_ce_n(sram_ce_n),
      .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n), .sram_bs_n(sram_bs_n),
      .sram_addr(sram_addr), .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe),
      .sram_dq_in(sram_dq_in));

   function automatic logic [15:0] model_word(input logic [AW-1:0] a);
      return model_mem.exists(a) ? model_mem[a] : 16'h0000;
   endfunction

   function automatic logic [15:0] ref_word(input logic [AW-1:0] a);
      return ref_mem.exists(a) ? ref_mem[a] : 16'h0000;
   endfunction

   function automatic logic [15:0] lane_mask(input logic [1:0] be);
      return {{8{be[1]}}, {8{be[0]}}};
   endfunction

   // Memory model: drives enabled lanes during a read, floats others to a fixed pattern
   logic mem_drive;
   assign mem_drive = !sram_ce_n && !sram_oe_n && sram_we_n;
   always_comb begin
      logic [15:0] w;
      w = model_word(sram_addr);
      for (int i = 0; i < 2; i++) begin
         if (sram_dq_oe)
            sram_dq_in[i*8 +: 8] = sram_dq_out[i*8 +: 8];
         else if (mem_drive && !sram_bs_n[i])
            sram_dq_in[i*8 +: 8] = w[i*8 +: 8];
         else
            sram_dq_in[i*8 +: 8] = 8'h5A;
      end
   end

   always @(posedge sram_we_n) begin
      if (rst_n && !sram_ce_n) begin
         logic [15:0] w;
         w = model_word(sram_addr);
         checks++;
         if (!sram_dq_oe) begin
            errors++;
            $display("FAIL R2 data drive at write end: got %0b expected 1", sram_dq_oe);
         end
         for (int i = 0; i < 2; i++)
            if (!sram_bs_n[i]) w[i*8 +: 8] = sram_dq_out[i*8 +: 8];
         model_mem[sram_addr] = w;
      end
   end

   // Pin monitors: pulse widths, overlap and turnaround
   int we_run = 0, oe_run = 0, gap = 0;
   bit gap_armed = 0;
   logic prev_oe_n = 1'b1;
   always @(negedge clk) begin
      if (rst_n) begin
         if (!sram_we_n) we_run++;
         else if (we_run != 0) begin
            checks++;
            if (we_run != T_WPULSE) begin
               errors++;
               $display("FAIL R2 write pulse width: got %0d expected %0d", we_run, T_WPULSE);
            end
            we_run = 0;
         end
         if (!sram_oe_n) oe_run++;
         else if (oe_run != 0) begin
            checks++;
            if (oe_run != T_RACC) begin
               errors++;
               $display("FAIL R4 read window: got %0d expected %0d", oe_run, T_RACC);
            end
            oe_run = 0;
         end
         if (!sram_oe_n && sram_dq_oe) begin
            checks++; errors++;
            $display("FAIL R9 overlap: oe_n %0b dq_oe %0b expected no overlap", sram_oe_n, sram_dq_oe);
         end
         if (sram_oe_n && !prev_oe_n) begin
            gap_armed = 1; gap = 0;
         end else if (gap_armed) begin
            if (sram_dq_oe) begin
               checks++;
               if (gap < T_TURN) begin
                  errors++;
                  $display("FAIL R9 turnaround: got %0d expected >= %0d", gap, T_TURN);
               end
               gap_armed = 0;
            end else if (!sram_oe_n) gap_armed = 0;
            else gap++;
         end
         prev_oe_n = sram_oe_n;
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         errors++; checks++;
         $display("FAIL watchdog: got %0d cycles expected completion", cyc);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string what, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: got %0h expected %0h", what, got, exp);
      end
   endtask

   task automatic do_op(input logic wr, input logic [AW-1:0] a, input logic [1:0] be,
                        input logic [15:0] wd, output logic [15:0] rd);
      int lat;
      bit started;
      host_wr = wr; host_addr = a; host_be = be; host_wdata = wd; host_req = 1'b1;
      lat = 0; started = 0;
      do begin
         @(negedge clk);
         if (!started && !sram_ce_n) begin
            started = 1;
            chk(sram_addr == a, "R10 address", 32'(sram_addr), 32'(a));
            chk(sram_bs_n == ~be, "R3 strobes", 32'(sram_bs_n), 32'(~be));
            host_addr = AW'($urandom); host_wdata = 16'($urandom); host_be = 2'($urandom);
         end
         if (started) lat++;
      end while (!host_ack);
      rd = host_rdata;
      host_req = 1'b0;
      chk(lat == (wr ? WR_LAT : T_RACC) + 1, "R5 latency", 32'(lat), 32'((wr ? WR_LAT : T_RACC) + 1));
      if (wr) ref_mem[a] = (ref_word(a) & ~lane_mask(be)) | (wd & lane_mask(be));
      else chk(rd == (ref_word(a) & lane_mask(be)), "R4 read word", 32'(rd),
               32'(ref_word(a) & lane_mask(be)));
   endtask

   task automatic idle_check();
      @(negedge clk);
      chk(!host_ack, "R5 ack single cycle", 32'(host_ack), 32'h0);
      chk(sram_ce_n && sram_oe_n && sram_we_n && sram_bs_n == 2'b11 && !sram_dq_oe,
          "R6 standby pins", {27'h0, sram_ce_n, sram_oe_n, sram_we_n, sram_bs_n}, 32'h1f);
   endtask

   initial begin
      logic [15:0] rd;
      logic [AW-1:0] pool [8];
      void'($urandom(32'd1234));
      pool = '{18'h00000, 18'h3FFFF, 18'h00001, 18'h20000, 18'h15555, 18'h2AAAA, 18'h00100, 18'h3FFFE};
      repeat (3) @(negedge clk);
      chk(sram_ce_n && sram_we_n && sram_oe_n && sram_bs_n == 2'b11 && !sram_dq_oe && !host_ack,
          "R1 reset pins", {26'h0, sram_ce_n, sram_we_n, sram_oe_n, sram_bs_n, sram_dq_oe}, 32'h3e);
      rst_n = 1'b1;
      @(negedge clk);
      chk(sram_ce_n && sram_we_n && sram_oe_n && !sram_dq_oe && !host_ack, "R1 after reset",
          {28'h0, sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe}, 32'he);

      // R2 R10: full-word writes at both ends of the address range
      do_op(1'b1, 18'h00000, 2'b11, 16'h1234, rd);
      idle_check();
      do_op(1'b1, 18'h3FFFF, 2'b11, 16'hBEEF, rd);
      do_op(1'b0, 18'h00000, 2'b11, 16'h0, rd);
      do_op(1'b0, 18'h3FFFF, 2'b11, 16'h0, rd);
      idle_check();
      // R3: upper-only write merges with the old lower byte
      do_op(1'b1, 18'h00000, 2'b10, 16'hA5C3, rd);
      do_op(1'b0, 18'h00000, 2'b11, 16'h0, rd);
      chk(rd == 16'hA534, "R3 lane merge", 32'(rd), 32'hA534);
      // R4: lower-only read returns zero upper byte
      do_op(1'b0, 18'h3FFFF, 2'b01, 16'h0, rd);
      chk(rd == 16'h00EF, "R4 masked lane", 32'(rd), 32'h00EF);
      // R7: no-lane write leaves memory unchanged
      do_op(1'b1, 18'h3FFFF, 2'b00, 16'h0000, rd);
      do_op(1'b0, 18'h3FFFF, 2'b11, 16'h0, rd);
      chk(rd == 16'hBEEF, "R7 empty write", 32'(rd), 32'hBEEF);
      // R9: read immediately followed by write
      do_op(1'b0, 18'h00000, 2'b11, 16'h0, rd);
      do_op(1'b1, 18'h00001, 2'b11, 16'h7E81, rd);
      idle_check();

      // R8: random mix, host inputs scrambled during every access
      for (int n = 0; n < 300; n++) begin
         logic [AW-1:0] a;
         a = ($urandom_range(0, 3) == 0) ? AW'($urandom) : pool[$urandom_range(0, 7)];
         do_op(1'($urandom), a, 2'($urandom), 16'($urandom), rd);
      end
      for (int k = 0; k < 8; k++) do_op(1'b0, pool[k], 2'b11, 16'h0, rd);
      idle_check();

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule